// File: doc/BRIEF.md
# Error Flag Event Recorder

This block holds a bank of 2048 single-bit error flags and records how they were raised. Requests carry an 11-bit flag index and a polarity: a set request makes the flag TRUE and a reset request makes it FALSE. The block keeps the number of flags that are TRUE. It logs, in arrival order, the indices of the first nineteen FALSE-to-TRUE events. It also latches the calendar stamp presented on its inputs when the first flag goes TRUE after a clear.

A clear strobe wipes flags, count, log and stamp, but only while the clear-enable bit is high. With that bit low, the state survives everything except the asynchronous reset, which stands for a fresh program load. A mode change has no path into the block, so no mode change can touch the state. Software sees the state through a combinational register read port. An any-active output is also driven directly.

Top module: `err_flag_recorder`

## Requirements
- R1: The bank has 2048 flags, indexed 0 to 2047. When `req_valid` is high, `req_set`=1 makes flag `req_idx` TRUE and `req_set`=0 makes it FALSE.
- R2: A set request on a FALSE flag raises the count (read address 0) by one. The new value is visible after the clock edge that accepts the request.
- R3: A set request on a flag that is already TRUE changes neither the count, the log nor the stamp.
- R4: A reset request on a TRUE flag lowers the count by one. A reset request on a FALSE flag has no effect. Log entries and the stamp hold through resets.
- R5: Log slot k (read address 8+k, k = 0..18) holds the index of the (k+1)-th FALSE-to-TRUE event since the last clear. Read address 5 gives the number of filled slots.
- R6: Once 19 slots are filled, further FALSE-to-TRUE events still raise the count, but the log and the fill level stay unchanged. The count never exceeds 2048.
- R7: `any_active`, and bit 0 of read address 1, is 1 exactly while the count is nonzero.
- R8: On the first FALSE-to-TRUE event after a clear, the stamp words are captured and read back at address 2 (minute/second), 3 (day/hour) and 4 (year/month). They do not change again until a clear.
- R9: `clr_strobe` with `clr_enable`=1 zeroes flags, count, fill, log and stamp after the next edge. A request in the same cycle is discarded.
- R10: `clr_strobe` with `clr_enable`=0 has no effect on any state.
- R11: `rst_n` low clears all state at once, without waiting for a clock edge.
- R12: Read addresses 6, 7 and 27 to 31 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low program-reload reset |
| req_valid | input | 1 | Flag write request strobe |
| req_set | input | 1 | 1 = set operation, 0 = reset operation |
| req_idx | input | 11 | Index of the flag to write |
| ts_min_sec | input | 16 | Running stamp: minute/second word |
| ts_day_hour | input | 16 | Running stamp: day/hour word |
| ts_year_mon | input | 16 | Running stamp: year/month word |
| clr_strobe | input | 1 | Clear request |
| clr_enable | input | 1 | Configuration bit that permits the clear |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| any_active | output | 1 | At least one flag is TRUE |

## Verification
A clear and a flag write can fall in the same cycle. The bench provokes this by driving an enabled clear strobe together with a set request on an index that is FALSE. After the edge, the count, fill level and stamp must all read zero. A later set on the same index must then raise the count to one, which shows that the flag itself never went TRUE. The same collision is repeated with the clear disabled: there the set request must take effect and the existing log must be kept.

// File: rtl/efr_pkg.sv
package efr_pkg;
  localparam int unsigned DATA_W        = 16;
  localparam int unsigned ADDR_COUNT    = 0;
  localparam int unsigned ADDR_STATUS   = 1;
  localparam int unsigned ADDR_TS_MS    = 2;
  localparam int unsigned ADDR_TS_DH    = 3;
  localparam int unsigned ADDR_TS_YM    = 4;
  localparam int unsigned ADDR_FILL     = 5;
  localparam int unsigned ADDR_LOG_BASE = 8;

  typedef struct packed {
    logic [DATA_W-1:0] min_sec;
    logic [DATA_W-1:0] day_hour;
    logic [DATA_W-1:0] year_mon;
  } efr_stamp_t;
endpackage

// File: rtl/efr_flag_bank.sv
module efr_flag_bank #(
  parameter int unsigned NUM_FLAGS = 2048,
  parameter int unsigned IDX_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_val,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             clr,
  output logic             cur_bit,
  output logic             any_set
);
  logic [NUM_FLAGS-1:0] flags_q;
  logic [NUM_FLAGS-1:0] flags_d;
  logic                 flags_en;

  always_comb begin
    flags_d  = flags_q;
    flags_en = clr | wr_en;
    if (clr) begin
      flags_d = '0;
    end else if (wr_en) begin
      flags_d[wr_idx] = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  assign cur_bit = flags_q[wr_idx];
  assign any_set = |flags_q;
endmodule

// File: rtl/efr_event_log.sv
module efr_event_log
  import efr_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 2048,
  parameter int unsigned IDX_W     = 11,
  parameter int unsigned LOG_DEPTH = 19,
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned FILL_W    = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rise,
  input  logic                       fall,
  input  logic                       clr,
  input  logic [IDX_W-1:0]           idx,
  input  efr_stamp_t                 stamp_in,
  output logic [CNT_W-1:0]           cnt,
  output logic [FILL_W-1:0]          fill,
  output efr_stamp_t                 stamp,
  output logic [LOG_DEPTH*IDX_W-1:0] log_flat
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(NUM_FLAGS);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(LOG_DEPTH);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              fill_en;
  efr_stamp_t        stamp_q, stamp_d;
  logic              stamp_en;
  logic              log_wr;

  assign log_wr = rise && (fill_q != FILL_MAX);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (rise && (cnt_q != CNT_MAX)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end else if (fall && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_comb begin
    fill_d  = fill_q;
    fill_en = clr | log_wr;
    if (clr) begin
      fill_d = '0;
    end else if (log_wr) begin
      fill_d = fill_q + 1'b1;
    end
  end

  always_comb begin
    stamp_d  = stamp_q;
    stamp_en = clr | (rise && (fill_q == '0));
    if (clr) begin
      stamp_d = '0;
    end else if (stamp_en) begin
      stamp_d = stamp_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fill_q  <= '0;
      stamp_q <= '0;
    end else begin
      if (cnt_en)   cnt_q   <= cnt_d;
      if (fill_en)  fill_q  <= fill_d;
      if (stamp_en) stamp_q <= stamp_d;
    end
  end

  for (genvar k = 0; k < LOG_DEPTH; k++) begin : g_slot
    logic [IDX_W-1:0] slot_q, slot_d;
    logic             slot_en;

    always_comb begin
      slot_en = clr | (log_wr && (fill_q == FILL_W'(k)));
      slot_d  = clr ? '0 : idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= slot_d;
      end
    end

    assign log_flat[k*IDX_W +: IDX_W] = slot_q;
  end

  assign cnt   = cnt_q;
  assign fill  = fill_q;
  assign stamp = stamp_q;
endmodule

// File: rtl/efr_read_mux.sv
module efr_read_mux
  import efr_pkg::*;
#(
  parameter int unsigned IDX_W     = 11,
  parameter int unsigned LOG_DEPTH = 19,
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned FILL_W    = 5,
  parameter int unsigned RD_AW     = 5
) (
  input  logic [RD_AW-1:0]           rd_addr,
  input  logic [CNT_W-1:0]           cnt,
  input  logic [FILL_W-1:0]          fill,
  input  logic                       any_on,
  input  efr_stamp_t                 stamp,
  input  logic [LOG_DEPTH*IDX_W-1:0] log_flat,
  output logic [DATA_W-1:0]          rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_addr == RD_AW'(ADDR_COUNT))  rd_data = DATA_W'(cnt);
    if (rd_addr == RD_AW'(ADDR_STATUS)) rd_data = DATA_W'(any_on);
    if (rd_addr == RD_AW'(ADDR_TS_MS))  rd_data = stamp.min_sec;
    if (rd_addr == RD_AW'(ADDR_TS_DH))  rd_data = stamp.day_hour;
    if (rd_addr == RD_AW'(ADDR_TS_YM))  rd_data = stamp.year_mon;
    if (rd_addr == RD_AW'(ADDR_FILL))   rd_data = DATA_W'(fill);
    for (int k = 0; k < LOG_DEPTH; k++) begin
      if (rd_addr == RD_AW'(ADDR_LOG_BASE + k)) begin
        rd_data = DATA_W'(log_flat[k*IDX_W +: IDX_W]);
      end
    end
  end
endmodule

// File: rtl/err_flag_recorder.sv
module err_flag_recorder
  import efr_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 2048,
  parameter int unsigned LOG_DEPTH = 19,
  localparam int unsigned IDX_W    = $clog2(NUM_FLAGS),
  localparam int unsigned CNT_W    = $clog2(NUM_FLAGS + 1),
  localparam int unsigned FILL_W   = $clog2(LOG_DEPTH + 1),
  localparam int unsigned RD_AW    = $clog2(ADDR_LOG_BASE + LOG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_set,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] ts_min_sec,
  input  logic [DATA_W-1:0] ts_day_hour,
  input  logic [DATA_W-1:0] ts_year_mon,
  input  logic              clr_strobe,
  input  logic              clr_enable,
  input  logic [RD_AW-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              any_active
);
  logic                       clr;
  logic                       op_valid;
  logic                       cur_bit;
  logic                       bank_any;
  logic                       rise;
  logic                       fall;
  logic [CNT_W-1:0]           cnt;
  logic [FILL_W-1:0]          fill;
  efr_stamp_t                 stamp_in;
  efr_stamp_t                 stamp;
  logic [LOG_DEPTH*IDX_W-1:0] log_flat;

  assign clr      = clr_strobe & clr_enable;
  assign op_valid = req_valid & ~clr;
  assign rise     = op_valid &  req_set & ~cur_bit;
  assign fall     = op_valid & ~req_set &  cur_bit;
  assign stamp_in = '{min_sec: ts_min_sec, day_hour: ts_day_hour, year_mon: ts_year_mon};

  efr_flag_bank #(
    .NUM_FLAGS (NUM_FLAGS),
    .IDX_W     (IDX_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (op_valid),
    .wr_val  (req_set),
    .wr_idx  (req_idx),
    .clr     (clr),
    .cur_bit (cur_bit),
    .any_set (bank_any)
  );

  efr_event_log #(
    .NUM_FLAGS (NUM_FLAGS),
    .IDX_W     (IDX_W),
    .LOG_DEPTH (LOG_DEPTH),
    .CNT_W     (CNT_W),
    .FILL_W    (FILL_W)
  ) u_log (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise),
    .fall     (fall),
    .clr      (clr),
    .idx      (req_idx),
    .stamp_in (stamp_in),
    .cnt      (cnt),
    .fill     (fill),
    .stamp    (stamp),
    .log_flat (log_flat)
  );

  assign any_active = (cnt != '0);

  efr_read_mux #(
    .IDX_W     (IDX_W),
    .LOG_DEPTH (LOG_DEPTH),
    .CNT_W     (CNT_W),
    .FILL_W    (FILL_W),
    .RD_AW     (RD_AW)
  ) u_rd (
    .rd_addr  (rd_addr),
    .cnt      (cnt),
    .fill     (fill),
    .any_on   (any_active),
    .stamp    (stamp),
    .log_flat (log_flat),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/efr_checker.sv
module efr_checker #(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned FILL_W    = 5,
  parameter int unsigned LOG_DEPTH = 19,
  parameter int unsigned NUM_FLAGS = 2048
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_set,
  input logic              clr_strobe,
  input logic              clr_enable,
  input logic              flag_bit,
  input logic              bank_any,
  input logic              any_active,
  input logic [CNT_W-1:0]  cnt,
  input logic [FILL_W-1:0] fill,
  input logic [47:0]       stamp_flat
);
  logic clr_ok;
  assign clr_ok = clr_strobe && clr_enable;

  // R2: a set on a FALSE flag raises the count by one
  assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_set && !flag_bit && !clr_ok && cnt != CNT_W'(NUM_FLAGS))
      |=> (cnt == $past(cnt) + 1'b1));

  // R4: a reset on a TRUE flag lowers the count by one
  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_set && flag_bit && !clr_ok) |=> (cnt == $past(cnt) - 1'b1));

  // R3: a set on a TRUE flag leaves the count alone
  assert_dup_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_set && flag_bit && !clr_ok) |=> $stable(cnt));

  // R6: a full log stays full until a clear
  assert_log_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FILL_W'(LOG_DEPTH) && !clr_ok) |=> (fill == FILL_W'(LOG_DEPTH)));

  // R7: the indicator follows the flag bank itself
  assert_any_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_active == bank_any);

  // R8: the stamp holds once the log has an entry
  assert_stamp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill != '0 && !clr_ok) |=> $stable(stamp_flat));

  // R9: an enabled clear empties count and log
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ok |=> (cnt == '0 && fill == '0 && stamp_flat == '0));

  // R10: a blocked clear with no request changes nothing
  assert_clear_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_strobe && !clr_enable && !req_valid) |=> ($stable(cnt) && $stable(fill)));
endmodule

bind err_flag_recorder efr_checker #(
  .CNT_W     (CNT_W),
  .FILL_W    (FILL_W),
  .LOG_DEPTH (LOG_DEPTH),
  .NUM_FLAGS (NUM_FLAGS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_set    (req_set),
  .clr_strobe (clr_strobe),
  .clr_enable (clr_enable),
  .flag_bit   (cur_bit),
  .bank_any   (bank_any),
  .any_active (any_active),
  .cnt        (cnt),
  .fill       (fill),
  .stamp_flat (stamp)
);

// File: tb/sim_err_flag_recorder.sv
`timescale 1ns/1ps
module sim_err_flag_recorder;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_set;
  logic [10:0] req_idx;
  logic [15:0] ts_min_sec;
  logic [15:0] ts_day_hour;
  logic [15:0] ts_year_mon;
  logic        clr_strobe;
  logic        clr_enable;
  logic [4:0]  rd_addr;
  logic [15:0] rd_data;
  logic        any_active;

  int checks;
  int errors;
  bit done;

  err_flag_recorder u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_set     (req_set),
    .req_idx     (req_idx),
    .ts_min_sec  (ts_min_sec),
    .ts_day_hour (ts_day_hour),
    .ts_year_mon (ts_year_mon),
    .clr_strobe  (clr_strobe),
    .clr_enable  (clr_enable),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .any_active  (any_active)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%h) expected %0d (0x%h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic rd(input int addr, output logic [15:0] val);
    rd_addr = 5'(addr);
    #0.5;
    val = rd_data;
  endtask

  task automatic chk_reg(input string tag, input int addr, input logic [15:0] exp);
    logic [15:0] v;
    rd(addr, v);
    chk(tag, v, exp);
  endtask

  task automatic set_stamp(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    ts_min_sec  = a;
    ts_day_hour = b;
    ts_year_mon = c;
  endtask

  // one request through one clock edge, returns at the following negedge
  task automatic op(input logic s, input int idx);
    @(negedge clk);
    req_valid = 1'b1;
    req_set   = s;
    req_idx   = 11'(idx);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic clear(input logic en);
    @(negedge clk);
    clr_strobe = 1'b1;
    clr_enable = en;
    @(negedge clk);
    clr_strobe = 1'b0;
  endtask

  task automatic t_reset_state;
    chk_reg("R11 count after reset", 0, 16'd0);
    chk_reg("R11 fill after reset", 5, 16'd0);
    chk_reg("R11 stamp after reset", 2, 16'd0);
    chk("R7 any_active after reset", 16'(any_active), 16'd0);
  endtask

  task automatic t_basic_sets;
    set_stamp(16'h1234, 16'h0509, 16'h2403);
    op(1'b1, 5);
    chk_reg("R2 count after first set", 0, 16'd1);
    chk("R7 any_active port", 16'(any_active), 16'd1);
    chk_reg("R7 status register", 1, 16'd1);
    chk_reg("R5 slot 0", 8, 16'd5);
    chk_reg("R8 stamp min/sec", 2, 16'h1234);
    chk_reg("R8 stamp day/hour", 3, 16'h0509);
    chk_reg("R8 stamp year/month", 4, 16'h2403);
    set_stamp(16'hAAAA, 16'hBBBB, 16'hCCCC);
    op(1'b1, 2047);
    op(1'b1, 0);
    chk_reg("R1 count with top and bottom index", 0, 16'd3);
    chk_reg("R5 slot 1", 9, 16'd2047);
    chk_reg("R5 slot 2", 10, 16'd0);
    chk_reg("R5 fill level", 5, 16'd3);
    chk_reg("R8 stamp held on later set", 2, 16'h1234);
  endtask

  task automatic t_dup_set;
    op(1'b1, 5);
    chk_reg("R3 count after duplicate set", 0, 16'd3);
    chk_reg("R3 fill after duplicate set", 5, 16'd3);
    chk_reg("R3 slot 3 untouched", 11, 16'd0);
    chk_reg("R3 stamp after duplicate set", 3, 16'h0509);
  endtask

  task automatic t_resets;
    op(1'b0, 2047);
    chk_reg("R4 count after reset of TRUE flag", 0, 16'd2);
    op(1'b0, 2047);
    chk_reg("R4 count after reset of FALSE flag", 0, 16'd2);
    op(1'b0, 5);
    op(1'b0, 0);
    chk_reg("R4 count after all reset", 0, 16'd0);
    chk("R7 any_active drops", 16'(any_active), 16'd0);
    chk_reg("R4 log kept", 9, 16'd2047);
    chk_reg("R4 fill kept", 5, 16'd3);
    chk_reg("R4 stamp kept", 4, 16'h2403);
    op(1'b1, 2047);
    chk_reg("R1 flag re-set after reset", 0, 16'd1);
    chk_reg("R8 no recapture without clear", 2, 16'h1234);
  endtask

  task automatic t_overflow;
    clear(1'b1);
    set_stamp(16'h0102, 16'h0304, 16'h0506);
    for (int i = 0; i < 25; i++) begin
      op(1'b1, 100 + i);
      if (i == 0) set_stamp(16'hFFFF, 16'hFFFF, 16'hFFFF);
    end
    chk_reg("R6 count beyond log depth", 0, 16'd25);
    chk_reg("R6 fill capped", 5, 16'd19);
    chk_reg("R6 last slot", 26, 16'd118);
    chk_reg("R5 middle slot", 15, 16'd107);
    chk_reg("R8 stamp after clear", 2, 16'h0102);
    chk_reg("R8 stamp year/month after clear", 4, 16'h0506);
  endtask

  task automatic t_blocked_clear;
    clear(1'b0);
    chk_reg("R10 count kept", 0, 16'd25);
    chk_reg("R10 fill kept", 5, 16'd19);
    chk_reg("R10 stamp kept", 3, 16'h0304);
    // blocked clear alongside a set: the set proceeds
    @(negedge clk);
    clr_strobe = 1'b1; clr_enable = 1'b0;
    req_valid = 1'b1; req_set = 1'b1; req_idx = 11'd7;
    @(negedge clk);
    clr_strobe = 1'b0; req_valid = 1'b0;
    chk_reg("R10 set proceeds with clear blocked", 0, 16'd26);
    chk_reg("R10 slot 0 kept", 8, 16'd100);
  endtask

  task automatic t_collision;
    @(negedge clk);
    clr_strobe = 1'b1; clr_enable = 1'b1;
    req_valid = 1'b1; req_set = 1'b1; req_idx = 11'd9;
    @(negedge clk);
    clr_strobe = 1'b0; req_valid = 1'b0;
    chk_reg("R9 count cleared", 0, 16'd0);
    chk_reg("R9 fill cleared", 5, 16'd0);
    chk_reg("R9 slot cleared", 8, 16'd0);
    chk_reg("R9 stamp cleared", 2, 16'd0);
    op(1'b1, 9);
    chk_reg("R9 colliding set was discarded", 0, 16'd1);
    op(1'b1, 100);
    chk_reg("R9 old flag cleared", 0, 16'd2);
  endtask

  task automatic t_unmapped;
    chk_reg("R12 addr 6", 6, 16'd0);
    chk_reg("R12 addr 7", 7, 16'd0);
    chk_reg("R12 addr 27", 27, 16'd0);
    chk_reg("R12 addr 31", 31, 16'd0);
  endtask

  task automatic t_async_reset;
    @(negedge clk);
    #0.5;
    rst_n = 1'b0;
    #0.5;
    chk("R11 async count clear", 16'(any_active), 16'd0);
    chk_reg("R11 async count register", 0, 16'd0);
    chk_reg("R11 async slot clear", 8, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_set = 1'b0; req_idx = '0;
    clr_strobe = 1'b0; clr_enable = 1'b0; rd_addr = '0;
    set_stamp(16'd0, 16'd0, 16'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_basic_sets();
    t_dup_set();
    t_resets();
    t_overflow();
    t_blocked_clear();
    t_collision();
    t_unmapped();
    t_async_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule